// File: doc/BRIEF.md
# Peripheral Control/Status Register with Priority-Gated Interrupt

This block is the command and status word of a peripheral that sits on a 16-bit register bus. It combines two kinds of bits. Some are status bits that only the device side can change: three individual error flags, their summary, busy and done. Others are control bits that the bus master writes: interrupt enable and go. The bus reads the whole word at any time through a combinational read path.

The block watches the "attention" condition, which is done OR any error. It raises a pending interrupt in three cases:

- attention rises while interrupt enable is set;
- interrupt enable is switched on while attention is already set;
- both happen at once.

The pending request reaches the processor only while this device's fixed priority level is strictly above the 3-bit processor priority. The request stays pending until an acknowledge arrives or interrupt enable is cleared. A system init pulse drops the control bits and leaves the device-owned status alone.

Top module: `dev_csr_irq`

## Requirements
- R1: Read bit 15 is 1 exactly when any of the three individual error bits (read bits 14, 13, 12, set by `dev_err_set[i]` for bit 12+i) is 1.
- R2: The word reads busy at bit 11, done at bit 7, interrupt enable at bit 6 and go at bit 0; a low-lane write of 16'hFFFF makes the word read 16'h0041 when no status bit is set.
- R3: With interrupt enable at 1, a done or error set strobe seen at clock edge N makes `irq` 1 after edge N+1 (priority permitting).
- R4: Writing interrupt enable from 0 to 1 while done or an error is already 1 raises the request after the following edge.
- R5: `irq` is 1 only when parameter DEV_LEVEL is strictly greater than `cpu_pri`; a pending request is held and appears once `cpu_pri` drops below the level; at `cpu_pri` 7 it never appears.
- R6: Bits 10:8 and 5:1 always read 0; writing ones to them or to status bits has no effect on the read value.
- R7: Done, busy and the error bits change only through their device strobes; a set and a clear strobe in the same cycle leave the bit at 1.
- R8: A `sys_init` pulse clears interrupt enable and go after the edge, leaves done and errors unchanged, and takes priority over a simultaneous bus write.
- R9: `irq_ack` or clearing interrupt enable drops the request; the request does not return while attention stays at 1, and a fresh 0-to-1 edge of attention re-arms it.
- R10: `bus_be[0]` enables the write of bits 7:0 and `bus_be[1]` that of bits 15:8; a write with `bus_be[0]` at 0 leaves interrupt enable and go unchanged.
- R11: After reset the word reads 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_init | input | 1 | System init pulse, clears control bits |
| bus_wr | input | 1 | Register write strobe |
| bus_be | input | 2 | Byte-lane enables: [0] low byte, [1] high byte |
| bus_wdata | input | 16 | Write data |
| rd_data | output | 16 | Current register word |
| dev_done_set | input | 1 | Device sets done |
| dev_done_clr | input | 1 | Device clears done |
| dev_busy_set | input | 1 | Device sets busy |
| dev_busy_clr | input | 1 | Device clears busy |
| dev_err_set | input | 3 | Device sets individual error bits |
| dev_err_clr | input | 3 | Device clears individual error bits |
| cpu_pri | input | 3 | Current processor priority |
| irq_ack | input | 1 | Acknowledge of the request |
| irq | output | 1 | Priority-qualified interrupt request |

## Verification
On every cycle, assertions check the following:

- the summary error bit follows an error set;
- done never moves without a device strobe;
- init and high-lane-only writes leave the right control state;
- an acknowledge retires the pending request;
- switching on enable with attention set arms a request;
- `irq` never appears at or below the processor priority.

Some behaviour depends on a sequence of stimuli, and only the bench scenarios can show it. This covers the exact two-edge latency from strobe to request and the request held back and then released as the priority drops. It also covers the absence of a second request while attention stays high, re-arming after attention falls and rises again, and set-over-clear when both strobes coincide.

// File: rtl/devcsr_pkg.sv
// Package: bit positions and the stored-state type of the peripheral
// control/status word. Assumes a 16-bit word with three error bits.
package devcsr_pkg;
    localparam int unsigned WORD_W     = 16;
    localparam int unsigned ERR_W      = 3;
    localparam int unsigned POS_ERRSUM = 15;
    localparam int unsigned POS_ERR_LO = 12;
    localparam int unsigned POS_BUSY   = 11;
    localparam int unsigned POS_DONE   = 7;
    localparam int unsigned POS_IE     = 6;
    localparam int unsigned POS_GO     = 0;

    typedef struct packed {
        logic [ERR_W-1:0] err;
        logic             busy;
        logic             done;
        logic             ie;
        logic             go;
    } csr_state_t;
endpackage

// File: rtl/csr_fields.sv
// csr_fields: storage of every bit of the control/status word.
// The device-owned bits (errors, busy, done) move only on device strobes,
// with set winning over clear. Control bits (ie, go) are written from the
// low byte lane; init clears them and wins over a write.
// Assumes strobes are synchronous to clk.
module csr_fields
    import devcsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_init,
    input  logic             wr_lo,
    input  logic             wd_ie,
    input  logic             wd_go,
    input  logic             done_set,
    input  logic             done_clr,
    input  logic             busy_set,
    input  logic             busy_clr,
    input  logic [ERR_W-1:0] err_set,
    input  logic [ERR_W-1:0] err_clr,
    output csr_state_t       st
);

    // Per-bit error flags, set dominant over clear.
    for (genvar g = 0; g < ERR_W; g++) begin : g_err
        always_ff @(posedge clk) begin
            if (!rst_n)           st.err[g] <= 1'b0;
            else if (err_set[g])  st.err[g] <= 1'b1;
            else if (err_clr[g])  st.err[g] <= 1'b0;
        end
    end

    // Device-owned done and busy flags, set dominant over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st.done <= 1'b0;
            st.busy <= 1'b0;
        end else begin
            if (done_set)      st.done <= 1'b1;
            else if (done_clr) st.done <= 1'b0;
            if (busy_set)      st.busy <= 1'b1;
            else if (busy_clr) st.busy <= 1'b0;
        end
    end

    // Bus-owned control bits; init has priority over a low-lane write.
    always_ff @(posedge clk) begin
        if (!rst_n || sys_init) begin
            st.ie <= 1'b0;
            st.go <= 1'b0;
        end else if (wr_lo) begin
            st.ie <= wd_ie;
            st.go <= wd_go;
        end
    end

    AST_ERR_SUM_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_set) |=> (|st.err)); // R1
    AST_DONE_DEVICE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_set && !done_clr) |=> $stable(st.done)); // R7
    AST_INIT_CLEARS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        sys_init |=> (!st.ie && !st.go)); // R8
    AST_CTRL_HOLD_NO_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !sys_init) |=> $stable({st.ie, st.go})); // R10

endmodule

// File: rtl/csr_irq_gen.sv
// csr_irq_gen: turns attention (done OR error) and interrupt enable into a
// pending request. It arms when ie and attention are both 1 now but were
// not both 1 one cycle earlier. Acknowledge or ie low retire it, and a
// new arm in the same cycle as an acknowledge wins.
// Assumes ie and attn come straight from registers.
module csr_irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic ie,
    input  logic attn,
    input  logic ack,
    output logic pend
);

    logic ie_q;
    logic attn_q;
    logic arm;

    // Arm when the (ie, attention) pair newly becomes both-high.
    always_comb arm = ie && attn && !(ie_q && attn_q);

    // Remember last cycle's ie and attention for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            attn_q <= 1'b0;
        end else begin
            ie_q   <= ie;
            attn_q <= attn;
        end
    end

    // Pending request flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !ie) pend <= 1'b0;
        else               pend <= (pend && !ack) || arm;
    end

    AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !arm) |=> !pend); // R9
    AST_IE_ON_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ie) && attn) |=> pend); // R4

endmodule

// File: rtl/csr_pri_gate.sv
// csr_pri_gate: forwards a pending, enabled request only while the device
// level is strictly above the processor priority. Assumes DEV_LEVEL fits
// in PRI_W bits.
module csr_pri_gate #(
    parameter int unsigned PRI_W     = 3,
    parameter int unsigned DEV_LEVEL = 4
) (
    input  logic             pend,
    input  logic             ie,
    input  logic [PRI_W-1:0] cpu_pri,
    output logic             irq
);

    localparam logic [PRI_W-1:0] LEVEL = PRI_W'(DEV_LEVEL);

    // Strict-greater priority qualification.
    always_comb irq = pend && ie && (LEVEL > cpu_pri);

endmodule

// File: rtl/dev_csr_irq.sv
// dev_csr_irq: top of the peripheral control/status word with interrupt
// request. Ties together field storage, request generation and the priority
// gate, and assembles the read word; unused positions read 0.
// Assumes a single synchronous clock and a synchronous active-low reset.
module dev_csr_irq
    import devcsr_pkg::*;
#(
    parameter int unsigned PRI_W     = 3,
    parameter int unsigned DEV_LEVEL = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_init,
    input  logic              bus_wr,
    input  logic [1:0]        bus_be,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] rd_data,
    input  logic              dev_done_set,
    input  logic              dev_done_clr,
    input  logic              dev_busy_set,
    input  logic              dev_busy_clr,
    input  logic [ERR_W-1:0]  dev_err_set,
    input  logic [ERR_W-1:0]  dev_err_clr,
    input  logic [PRI_W-1:0]  cpu_pri,
    input  logic              irq_ack,
    output logic              irq
);

    csr_state_t st;
    logic       pend;
    logic       attn;
    logic       unused_bits;

    // The high lane holds no writable bit; these inputs carry no state.
    assign unused_bits = ^{bus_be[1], bus_wdata[15:7], bus_wdata[5:1]};

    csr_fields i_fields (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_init (sys_init),
        .wr_lo    (bus_wr && bus_be[0]),
        .wd_ie    (bus_wdata[POS_IE]),
        .wd_go    (bus_wdata[POS_GO]),
        .done_set (dev_done_set),
        .done_clr (dev_done_clr),
        .busy_set (dev_busy_set),
        .busy_clr (dev_busy_clr),
        .err_set  (dev_err_set),
        .err_clr  (dev_err_clr),
        .st       (st)
    );

    // Attention: done or any individual error.
    always_comb attn = st.done || (|st.err);

    csr_irq_gen i_irq_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .ie    (st.ie),
        .attn  (attn),
        .ack   (irq_ack),
        .pend  (pend)
    );

    csr_pri_gate #(.PRI_W(PRI_W), .DEV_LEVEL(DEV_LEVEL)) i_pri_gate (
        .pend    (pend),
        .ie      (st.ie),
        .cpu_pri (cpu_pri),
        .irq     (irq)
    );

    // Read word assembly; every position not named here reads zero.
    always_comb begin
        rd_data = '0;
        rd_data[POS_ERRSUM]                    = |st.err;
        rd_data[POS_ERR_LO +: ERR_W]           = st.err;
        rd_data[POS_BUSY]                      = st.busy;
        rd_data[POS_DONE]                      = st.done;
        rd_data[POS_IE]                        = st.ie;
        rd_data[POS_GO]                        = st.go;
    end

    AST_PRI_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cpu_pri < PRI_W'(DEV_LEVEL))); // R5
    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rd_data[POS_IE]); // R9
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[10:8] == 3'b000) && (rd_data[5:1] == 5'b00000)); // R6

endmodule

// File: tb/test_dev_csr_irq.sv
module test_dev_csr_irq;
    localparam time CLK_PERIOD = 10ns;
    localparam int  LVL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sys_init = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_be = 2'b00;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] rd_data;
    logic        dev_done_set = 1'b0, dev_done_clr = 1'b0;
    logic        dev_busy_set = 1'b0, dev_busy_clr = 1'b0;
    logic [2:0]  dev_err_set = 3'b0, dev_err_clr = 3'b0;
    logic [2:0]  cpu_pri = 3'd0;
    logic        irq_ack = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    // Reference model state
    logic [2:0] m_err;
    logic m_busy, m_done, m_ie, m_go, m_pend, m_ieq, m_attnq;

    dev_csr_irq #(.DEV_LEVEL(LVL)) i_dev_csr_irq (
        .clk, .rst_n, .sys_init, .bus_wr, .bus_be, .bus_wdata, .rd_data,
        .dev_done_set, .dev_done_clr, .dev_busy_set, .dev_busy_clr,
        .dev_err_set, .dev_err_clr, .cpu_pri, .irq_ack, .irq
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] exp_rd();
        logic [15:0] w = '0;
        w[15] = |m_err;
        w[14:12] = m_err;
        w[11] = m_busy;
        w[7] = m_done;
        w[6] = m_ie;
        w[0] = m_go;
        return w;
    endfunction

    function automatic logic exp_irq();
        return m_pend && m_ie && (3'(LVL) > cpu_pri);
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        logic attn, arm;
        if (!rst_n) begin
            m_err = 0; m_busy = 0; m_done = 0; m_ie = 0; m_go = 0;
            m_pend = 0; m_ieq = 0; m_attnq = 0;
            return;
        end
        attn = m_done || (|m_err);
        arm = m_ie && attn && !(m_ieq && m_attnq);
        m_pend = m_ie ? ((m_pend && !irq_ack) || arm) : 1'b0;
        m_ieq = m_ie;
        m_attnq = attn;
        for (int i = 0; i < 3; i++)
            if (dev_err_set[i]) m_err[i] = 1'b1;
            else if (dev_err_clr[i]) m_err[i] = 1'b0;
        if (dev_done_set) m_done = 1'b1; else if (dev_done_clr) m_done = 1'b0;
        if (dev_busy_set) m_busy = 1'b1; else if (dev_busy_clr) m_busy = 1'b0;
        if (sys_init) begin m_ie = 0; m_go = 0; end
        else if (bus_wr && bus_be[0]) begin m_ie = bus_wdata[6]; m_go = bus_wdata[0]; end
    endtask

    // One clock: apply current inputs, update model, compare away from the edge.
    task automatic cyc(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check({tag, " word"}, rd_data, exp_rd());
        check({tag, " irq"}, {15'b0, irq}, {15'b0, exp_irq()});
    endtask

    task automatic idle();
        sys_init = 0; bus_wr = 0; bus_be = 0; bus_wdata = 0;
        dev_done_set = 0; dev_done_clr = 0; dev_busy_set = 0; dev_busy_clr = 0;
        dev_err_set = 0; dev_err_clr = 0; irq_ack = 0;
    endtask

    task automatic wr(input logic [1:0] be, input logic [15:0] d, input string tag);
        bus_wr = 1; bus_be = be; bus_wdata = d;
        cyc(tag);
        idle();
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        rst_n = 0;
        cyc("R11 reset");
        cyc("R11 reset");
        rst_n = 1;
        cyc("R11 idle");
        check("R11 word after reset", rd_data, 16'h0000);

        // R2 R6: all-ones on both lanes
        wr(2'b11, 16'hFFFF, "R2 R6 write ones");
        check("R2 R6 readback", rd_data, 16'h0041);
        // R10: high lane only leaves control bits
        wr(2'b10, 16'h0000, "R10 high-lane write");
        check("R10 control kept", rd_data, 16'h0041);
        wr(2'b01, 16'h0040, "R10 low-lane write");
        check("R10 low lane", rd_data, 16'h0040);

        // R3: done rise with ie on, two-edge latency
        cpu_pri = 3'd0;
        dev_done_set = 1; cyc("R3 done strobe"); idle();
        check("R3 irq not yet", {15'b0, irq}, 16'h0);
        cyc("R3 wait");
        check("R3 irq raised", {15'b0, irq}, 16'h1);

        // R5: priority gating
        cpu_pri = 3'd7; cyc("R5 pri7");
        check("R5 pri 7 blocks", {15'b0, irq}, 16'h0);
        cpu_pri = 3'd4; cyc("R5 pri equal");
        check("R5 equal level blocks", {15'b0, irq}, 16'h0);
        cpu_pri = 3'd3; cyc("R5 pri below");
        check("R5 held request appears", {15'b0, irq}, 16'h1);
        cpu_pri = 3'd0;

        // R9: ack and no re-request while attention stays
        irq_ack = 1; cyc("R9 ack"); idle();
        check("R9 ack drops", {15'b0, irq}, 16'h0);
        repeat (3) cyc("R9 steady attention");
        check("R9 no re-request", {15'b0, irq}, 16'h0);
        dev_done_clr = 1; cyc("R9 done clear"); idle();
        dev_done_set = 1; cyc("R9 done again"); idle();
        cyc("R9 rearm");
        check("R9 re-armed", {15'b0, irq}, 16'h1);
        wr(2'b01, 16'h0000, "R9 ie off");
        check("R9 ie off drops", {15'b0, irq}, 16'h0);

        // R4: enable while done already high
        wr(2'b01, 16'h0040, "R4 ie on");
        cyc("R4 wait");
        check("R4 raised by ie", {15'b0, irq}, 16'h1);

        // R7: write cannot touch done; set+clr set wins
        wr(2'b11, 16'h0000, "R7 write zeros");
        check("R7 done kept", rd_data & 16'h0080, 16'h0080);
        dev_busy_set = 1; dev_busy_clr = 1; dev_err_set = 3'b010; dev_err_clr = 3'b010;
        cyc("R7 set and clear"); idle();
        check("R7 set wins", rd_data & 16'hF800, 16'hA800);
        // R1
        check("R1 summary", {15'b0, rd_data[15]}, 16'h1);
        dev_err_clr = 3'b111; cyc("R1 clear errors"); idle();
        check("R1 summary clear", {15'b0, rd_data[15]}, 16'h0);

        // R8: init vs write, done kept
        wr(2'b01, 16'h0041, "R8 setup");
        sys_init = 1; bus_wr = 1; bus_be = 2'b01; bus_wdata = 16'h0041;
        cyc("R8 init"); idle();
        check("R8 init clears ctrl", rd_data & 16'h00C1, 16'h0080);

        // Random mix
        for (int n = 0; n < 600; n++) begin
            idle();
            sys_init = ($urandom_range(0, 31) == 0);
            bus_wr = ($urandom_range(0, 3) == 0);
            bus_be = 2'($urandom_range(0, 3));
            bus_wdata = 16'($urandom);
            dev_done_set = ($urandom_range(0, 5) == 0);
            dev_done_clr = ($urandom_range(0, 4) == 0);
            dev_busy_set = ($urandom_range(0, 4) == 0);
            dev_busy_clr = ($urandom_range(0, 4) == 0);
            dev_err_set = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b0;
            dev_err_clr = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b0;
            irq_ack = ($urandom_range(0, 5) == 0);
            cpu_pri = 3'($urandom);
            cyc("R1 R3 R5 R6 R7 R9 R10 random");
        end
        idle();
        cyc("final");
        finish_run();
    end
endmodule